// File: doc/BRIEF.md
# Block-Indexed Branch Target Buffer

This block predicts where instruction fetch goes next, working on whole 16-byte aligned fetch blocks. Each table set covers one such block with a single shared tag. Up to four branches inside that block live in the set's four ways, and each way records the low four address bits that locate its branch. A lookup takes a fetch address. The low four bits are the entry byte: fetch enters the block there, so branches below it are skipped. One cycle later the block answers whether a branch at or after the entry byte is predicted taken. If one is, it returns the offset, target, kind and speculative flag of the earliest such branch.

A single update port serves two callers. Decode uses it to allocate entries speculatively, with an empty direction history. Retirement uses it to train the two-bit direction counter, clear the speculative flag, or allocate the entry directly. A separate removal port invalidates an entry that turns out not to be a branch. When a set has no free way, a three-bit pseudo-LRU tree chooses the victim. The tree is refreshed on lookup hits, update hits and allocations.

Top module: `btb_block_pred`

## Requirements
- R1: After synchronous reset every way is invalid, so every lookup answers not-taken.
- R2: The set index is address bits [10:4] and the set tag is the bits above them. A lookup can only hit when its tag equals the set tag. An allocation with a different tag discards every way of that set before installing the new branch.
- R3: A decode allocation (`upd_retire`=0) of a branch not yet present sets its counter to 01 (weakly not-taken) and its speculative flag to 1. A fresh conditional entry therefore predicts not-taken.
- R4: A retire update (`upd_retire`=1) to a present branch trains its counter and clears its speculative flag. A retire update to an absent branch allocates it with counter 10 if taken or 01 if not, and with the speculative flag clear.
- R5: An entry whose kind is unconditional (`upd_uncond`=1) always predicts taken, whatever its counter holds.
- R6: Only valid ways whose offset is greater than or equal to the entry byte (`lk_addr[3:0]`) take part. Among those that predict taken, the smallest offset wins.
- R7: A removal request (`dl_valid`) whose tag, set and offset match a valid way invalidates that way. If the update port writes the same way in the same cycle, the removal wins.
- R8: The response follows a lookup by exactly one cycle (`resp_valid`). On a miss, `resp_off`, `resp_target`, `resp_uncond` and `resp_spec` are all zero.
- R9: Allocation fills the lowest-numbered invalid way first. When every way is valid, a 3-bit tree chooses the victim: bit0=0 selects ways 0/1, with bit1 picking way 1 when set; bit0=1 selects ways 2/3, with bit2 picking way 3 when set. A touched way's path bits are set to point away from it.
- R10: A conditional entry predicts taken when its counter is 10 or 11. A taken outcome increments the counter and a not-taken outcome decrements it, saturating at 00 and 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | ADDR_W | Fetch address; low 4 bits give the entry byte |
| resp_valid | output | 1 | Lookup response valid, one cycle after request |
| resp_hit | output | 1 | A predicted-taken branch was found |
| resp_off | output | 4 | Byte offset of the selected branch |
| resp_target | output | TGT_W | Target of the selected branch |
| resp_uncond | output | 1 | Selected branch is unconditional |
| resp_spec | output | 1 | Selected entry is still speculative |
| upd_valid | input | 1 | Update request |
| upd_retire | input | 1 | 1 = retire training, 0 = decode allocation |
| upd_addr | input | ADDR_W | Branch instruction address |
| upd_target | input | TGT_W | Branch target |
| upd_uncond | input | 1 | Branch kind: 1 = unconditional, 0 = conditional |
| upd_taken | input | 1 | Resolved direction (retire only) |
| dl_valid | input | 1 | Remove-entry request |
| dl_addr | input | ADDR_W | Address of the bogus branch entry |

## Verification
Properties check the one-cycle response timing and the zeroed fields on a miss on every cycle. They also check that a hit never reports an offset below the entry byte. The register state is checked as well: speculative flags are cleared after a retire, a decode allocation writes the weakly not-taken counter, and a removal leaves the way invalid. Some behaviours can only be shown by the bench's scenarios. These are the choice of the earliest taken branch among several ways, counter saturation at both ends, tag replacement of a whole set, and the pseudo-LRU victim after the set is full and lookup hits have touched it.

// File: rtl/btb_pkg.sv
`timescale 1ns/1ps
package btb_pkg;
    localparam int OFF_W  = 4;   // 16-byte block
    localparam int CNT_W  = 2;
    localparam int WAYS   = 4;
    localparam int WAY_W  = 2;
    localparam int PLRU_W = 3;

    localparam logic [CNT_W-1:0] CTR_WEAK_NT = 2'b01;
    localparam logic [CNT_W-1:0] CTR_WEAK_T  = 2'b10;
    localparam logic [CNT_W-1:0] CTR_MAX     = 2'b11;

    typedef enum logic {KIND_COND = 1'b0, KIND_UNCOND = 1'b1} br_kind_e;

    typedef struct packed {
        logic               valid;
        logic               spec;
        br_kind_e           kind;
        logic [CNT_W-1:0]   ctr;
        logic [OFF_W-1:0]   off;
    } way_meta_t;

    function automatic logic [PLRU_W-1:0] plru_touch(input logic [PLRU_W-1:0] t,
                                                     input logic [WAY_W-1:0]  w);
        logic [PLRU_W-1:0] r;
        r    = t;
        r[0] = ~w[1];
        if (!w[1]) r[1] = ~w[0];
        else       r[2] = ~w[0];
        return r;
    endfunction

    function automatic logic [WAY_W-1:0] plru_victim(input logic [PLRU_W-1:0] t);
        return t[0] ? {1'b1, t[2]} : {1'b0, t[1]};
    endfunction

    function automatic logic [CNT_W-1:0] ctr_next(input logic [CNT_W-1:0] c, input logic taken);
        if (taken) return (c == CTR_MAX) ? c : c + 1'b1;
        return (c == '0) ? c : c - 1'b1;
    endfunction

    function automatic logic predicts_taken(input br_kind_e k, input logic [CNT_W-1:0] c);
        return (k == KIND_UNCOND) || c[CNT_W-1];
    endfunction
endpackage

// File: rtl/btb_way_match.sv
`timescale 1ns/1ps
module btb_way_match
    import btb_pkg::*;
(
    input  logic [WAYS-1:0]             vld,
    input  logic [WAYS-1:0][OFF_W-1:0]  offs,
    input  logic                        tag_ok,
    input  logic [OFF_W-1:0]            off,
    output logic                        hit,
    output logic [WAY_W-1:0]            way
);
    logic [WAYS-1:0] match;

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign match[w] = tag_ok && vld[w] && (offs[w] == off);
    end

    always_comb begin
        hit = |match;
        way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (match[w]) way = WAY_W'(w);
        end
    end
endmodule

// File: rtl/btb_victim_sel.sv
`timescale 1ns/1ps
module btb_victim_sel
    import btb_pkg::*;
(
    input  logic [WAYS-1:0]     vld,
    input  logic                tag_ok,
    input  logic [PLRU_W-1:0]   plru,
    output logic [WAY_W-1:0]    victim
);
    logic [WAYS-1:0] free;

    for (genvar w = 0; w < WAYS; w++) begin : g_free
        assign free[w] = !tag_ok || !vld[w];
    end

    always_comb begin
        victim = plru_victim(plru);
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (free[w]) victim = WAY_W'(w);
        end
    end
endmodule

// File: rtl/btb_lookup_sel.sv
`timescale 1ns/1ps
module btb_lookup_sel
    import btb_pkg::*;
(
    input  logic [WAYS-1:0]             vld,
    input  logic [WAYS-1:0][OFF_W-1:0]  offs,
    input  logic [WAYS-1:0][CNT_W-1:0]  ctrs,
    input  logic [WAYS-1:0]             uncond,
    input  logic                        tag_ok,
    input  logic [OFF_W-1:0]            entry_off,
    output logic                        found,
    output logic [WAY_W-1:0]            sel
);
    logic [WAYS-1:0] cand;

    for (genvar w = 0; w < WAYS; w++) begin : g_cand
        assign cand[w] = tag_ok && vld[w] && (offs[w] >= entry_off)
                      && predicts_taken(br_kind_e'(uncond[w]), ctrs[w]);
    end

    always_comb begin
        logic [OFF_W-1:0] best;
        found = 1'b0;
        sel   = '0;
        best  = '1;
        for (int w = 0; w < WAYS; w++) begin
            if (cand[w] && (!found || offs[w] < best)) begin
                found = 1'b1;
                sel   = WAY_W'(w);
                best  = offs[w];
            end
        end
    end
endmodule

// File: rtl/btb_block_pred.sv
`timescale 1ns/1ps
module btb_block_pred
    import btb_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int TGT_W  = 32,
    parameter int SETS   = 128
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                lk_valid,
    input  logic [ADDR_W-1:0]   lk_addr,
    output logic                resp_valid,
    output logic                resp_hit,
    output logic [3:0]          resp_off,
    output logic [TGT_W-1:0]    resp_target,
    output logic                resp_uncond,
    output logic                resp_spec,
    input  logic                upd_valid,
    input  logic                upd_retire,
    input  logic [ADDR_W-1:0]   upd_addr,
    input  logic [TGT_W-1:0]    upd_target,
    input  logic                upd_uncond,
    input  logic                upd_taken,
    input  logic                dl_valid,
    input  logic [ADDR_W-1:0]   dl_addr
);
    localparam int IDX_W = $clog2(SETS);
    localparam int TAG_W = ADDR_W - OFF_W - IDX_W;

    // storage
    logic [TAG_W-1:0]                   tag_q  [SETS];
    way_meta_t [WAYS-1:0]               meta_q [SETS];
    logic [WAYS-1:0][TGT_W-1:0]         tgt_q  [SETS];
    logic [PLRU_W-1:0]                  plru_q [SETS];

    // address split
    logic [IDX_W-1:0] lk_set, up_set, dl_set;
    logic [TAG_W-1:0] lk_tag, up_tag, dl_tag;
    logic [OFF_W-1:0] lk_off, up_off, dl_off;
    assign lk_set = lk_addr[OFF_W +: IDX_W];
    assign up_set = upd_addr[OFF_W +: IDX_W];
    assign dl_set = dl_addr[OFF_W +: IDX_W];
    assign lk_tag = lk_addr[ADDR_W-1 -: TAG_W];
    assign up_tag = upd_addr[ADDR_W-1 -: TAG_W];
    assign dl_tag = dl_addr[ADDR_W-1 -: TAG_W];
    assign lk_off = lk_addr[OFF_W-1:0];
    assign up_off = upd_addr[OFF_W-1:0];
    assign dl_off = dl_addr[OFF_W-1:0];

    logic lk_tag_ok, up_tag_ok, dl_tag_ok;
    assign lk_tag_ok = (tag_q[lk_set] == lk_tag);
    assign up_tag_ok = (tag_q[up_set] == up_tag);
    assign dl_tag_ok = (tag_q[dl_set] == dl_tag);

    // per-way field views of the three addressed sets
    logic [WAYS-1:0]            lk_vld, lk_unc, up_vld, dl_vld;
    logic [WAYS-1:0][OFF_W-1:0] lk_offs, up_offs, dl_offs;
    logic [WAYS-1:0][CNT_W-1:0] lk_ctrs;
    for (genvar w = 0; w < WAYS; w++) begin : g_view
        assign lk_vld[w]  = meta_q[lk_set][w].valid;
        assign lk_unc[w]  = (meta_q[lk_set][w].kind == KIND_UNCOND);
        assign lk_offs[w] = meta_q[lk_set][w].off;
        assign lk_ctrs[w] = meta_q[lk_set][w].ctr;
        assign up_vld[w]  = meta_q[up_set][w].valid;
        assign up_offs[w] = meta_q[up_set][w].off;
        assign dl_vld[w]  = meta_q[dl_set][w].valid;
        assign dl_offs[w] = meta_q[dl_set][w].off;
    end

    logic             lk_found, up_hit, dl_hit;
    logic [WAY_W-1:0] lk_way, up_match_way, up_victim, dl_way, up_way;

    btb_lookup_sel u_lookup (
        .vld(lk_vld), .offs(lk_offs), .ctrs(lk_ctrs), .uncond(lk_unc),
        .tag_ok(lk_tag_ok), .entry_off(lk_off), .found(lk_found), .sel(lk_way)
    );
    btb_way_match u_up_match (
        .vld(up_vld), .offs(up_offs), .tag_ok(up_tag_ok), .off(up_off),
        .hit(up_hit), .way(up_match_way)
    );
    btb_way_match u_dl_match (
        .vld(dl_vld), .offs(dl_offs), .tag_ok(dl_tag_ok), .off(dl_off),
        .hit(dl_hit), .way(dl_way)
    );
    btb_victim_sel u_victim (
        .vld(up_vld), .tag_ok(up_tag_ok), .plru(plru_q[up_set]), .victim(up_victim)
    );

    assign up_way = up_hit ? up_match_way : up_victim;

    // new contents of the updated way
    way_meta_t up_new;
    always_comb begin
        up_new      = meta_q[up_set][up_way];
        up_new.kind = br_kind_e'(upd_uncond);
        if (up_hit) begin
            if (upd_retire) begin
                up_new.ctr  = ctr_next(up_new.ctr, upd_taken);
                up_new.spec = 1'b0;
            end
        end else begin
            up_new.valid = 1'b1;
            up_new.off   = up_off;
            up_new.spec  = !upd_retire;
            up_new.ctr   = (upd_retire && upd_taken) ? CTR_WEAK_T : CTR_WEAK_NT;
        end
    end

    way_meta_t lk_sel_meta;
    assign lk_sel_meta = meta_q[lk_set][lk_way];

    // checker tracking registers
    logic             ret_chk_q, alloc_chk_q, dl_chk_q;
    logic [IDX_W-1:0] ret_set_q, alloc_set_q, dl_set_q;
    logic [WAY_W-1:0] ret_way_q, alloc_way_q, dl_way_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) begin
                tag_q[s]  <= '0;
                meta_q[s] <= '0;
                tgt_q[s]  <= '0;
                plru_q[s] <= '0;
            end
            resp_valid  <= 1'b0;
            resp_hit    <= 1'b0;
            resp_off    <= '0;
            resp_target <= '0;
            resp_uncond <= 1'b0;
            resp_spec   <= 1'b0;
            ret_chk_q   <= 1'b0;
            alloc_chk_q <= 1'b0;
            dl_chk_q    <= 1'b0;
            ret_set_q   <= '0;
            alloc_set_q <= '0;
            dl_set_q    <= '0;
            ret_way_q   <= '0;
            alloc_way_q <= '0;
            dl_way_q    <= '0;
        end else begin
            // lookup response
            resp_valid  <= lk_valid;
            resp_hit    <= lk_valid && lk_found;
            resp_off    <= (lk_valid && lk_found) ? lk_sel_meta.off : '0;
            resp_target <= (lk_valid && lk_found) ? tgt_q[lk_set][lk_way] : '0;
            resp_uncond <= lk_valid && lk_found && (lk_sel_meta.kind == KIND_UNCOND);
            resp_spec   <= lk_valid && lk_found && lk_sel_meta.spec;
            if (lk_valid && lk_found)
                plru_q[lk_set] <= plru_touch(plru_q[lk_set], lk_way);

            // allocate / train (later writes override the lookup touch)
            if (upd_valid) begin
                if (!up_tag_ok) begin
                    tag_q[up_set]  <= up_tag;
                    meta_q[up_set] <= '0;
                end
                meta_q[up_set][up_way] <= up_new;
                tgt_q[up_set][up_way]  <= upd_target;
                plru_q[up_set]         <= plru_touch(plru_q[up_set], up_way);
            end

            // removal wins over a same-cycle update of that way
            if (dl_valid && dl_hit)
                meta_q[dl_set][dl_way].valid <= 1'b0;

            ret_chk_q   <= upd_valid && upd_retire;
            ret_set_q   <= up_set;
            ret_way_q   <= up_way;
            alloc_chk_q <= upd_valid && !upd_retire && !up_hit;
            alloc_set_q <= up_set;
            alloc_way_q <= up_way;
            dl_chk_q    <= dl_valid && dl_hit;
            dl_set_q    <= dl_set;
            dl_way_q    <= dl_way;
        end
    end

    // ---------------- assertions ----------------
    way_meta_t ret_probe, alloc_probe, dl_probe;
    assign ret_probe   = meta_q[ret_set_q][ret_way_q];
    assign alloc_probe = meta_q[alloc_set_q][alloc_way_q];
    assign dl_probe    = meta_q[dl_set_q][dl_way_q];

    p_resp_follows_req_r8: assert property (@(posedge clk) disable iff (rst)
        lk_valid |=> resp_valid);
    p_resp_idle_r8: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |=> !resp_valid);
    p_miss_clean_r8: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && !resp_hit) |-> (resp_off == '0 && resp_target == '0 && !resp_uncond && !resp_spec));
    p_entry_floor_r6: assert property (@(posedge clk) disable iff (rst)
        lk_valid |=> (!resp_hit || resp_off >= $past(lk_addr[OFF_W-1:0])));
    p_retire_clears_spec_r4: assert property (@(posedge clk) disable iff (rst)
        ret_chk_q |-> !ret_probe.spec);
    p_fresh_weak_nt_r3: assert property (@(posedge clk) disable iff (rst)
        alloc_chk_q |-> (alloc_probe.ctr == CTR_WEAK_NT && alloc_probe.spec));
    p_removed_invalid_r7: assert property (@(posedge clk) disable iff (rst)
        dl_chk_q |-> !dl_probe.valid);
endmodule

// File: tb/btb_block_pred_tb_top.sv
`timescale 1ns/1ps
module btb_block_pred_tb_top;
    localparam int ADDR_W = 32;
    localparam int TGT_W  = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic              lk_valid = 1'b0;
    logic [ADDR_W-1:0] lk_addr = '0;
    logic              resp_valid, resp_hit, resp_uncond, resp_spec;
    logic [3:0]        resp_off;
    logic [TGT_W-1:0]  resp_target;
    logic              upd_valid = 1'b0, upd_retire = 1'b0, upd_uncond = 1'b0, upd_taken = 1'b0;
    logic [ADDR_W-1:0] upd_addr = '0;
    logic [TGT_W-1:0]  upd_target = '0;
    logic              dl_valid = 1'b0;
    logic [ADDR_W-1:0] dl_addr = '0;

    btb_block_pred dut_i (
        .clk(clk), .rst(rst),
        .lk_valid(lk_valid), .lk_addr(lk_addr),
        .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_off(resp_off),
        .resp_target(resp_target), .resp_uncond(resp_uncond), .resp_spec(resp_spec),
        .upd_valid(upd_valid), .upd_retire(upd_retire), .upd_addr(upd_addr),
        .upd_target(upd_target), .upd_uncond(upd_uncond), .upd_taken(upd_taken),
        .dl_valid(dl_valid), .dl_addr(dl_addr)
    );

    typedef struct {
        logic        hit;
        logic [3:0]  off;
        logic [31:0] tgt;
        logic        unc;
        logic        spec;
        string       req;
    } exp_t;

    exp_t sb_q[$];
    exp_t e;
    int checks = 0;
    int errors = 0;

    // monitor: compare each response with the oldest expectation
    always @(negedge clk) begin
        if (!rst && resp_valid) begin
            checks++;
            if (sb_q.size() == 0) begin
                errors++;
                $display("FAIL R8 unexpected response: actual=valid expected=none");
            end else begin
                e = sb_q.pop_front();
                if (resp_hit !== e.hit || resp_off !== e.off || resp_target !== e.tgt ||
                    resp_uncond !== e.unc || resp_spec !== e.spec) begin
                    errors++;
                    $display("FAIL %s: actual hit=%0b off=%0h tgt=%0h unc=%0b spec=%0b expected hit=%0b off=%0h tgt=%0h unc=%0b spec=%0b",
                             e.req, resp_hit, resp_off, resp_target, resp_uncond, resp_spec,
                             e.hit, e.off, e.tgt, e.unc, e.spec);
                end
            end
        end
    end

    task automatic lookup(input logic [31:0] a, input logic h, input logic [3:0] o,
                          input logic [31:0] t, input logic u, input logic s, input string r);
        exp_t x;
        x.hit = h; x.off = o; x.tgt = t; x.unc = u; x.spec = s; x.req = r;
        sb_q.push_back(x);
        lk_valid = 1'b1; lk_addr = a;
        @(posedge clk); #1;
        lk_valid = 1'b0;
    endtask

    task automatic miss(input logic [31:0] a, input string r);
        lookup(a, 1'b0, 4'h0, 32'h0, 1'b0, 1'b0, r);
    endtask

    task automatic update(input logic ret, input logic [31:0] a, input logic [31:0] t,
                          input logic u, input logic tk);
        upd_valid = 1'b1; upd_retire = ret; upd_addr = a; upd_target = t;
        upd_uncond = u; upd_taken = tk;
        @(posedge clk); #1;
        upd_valid = 1'b0;
    endtask

    task automatic remove(input logic [31:0] a);
        dl_valid = 1'b1; dl_addr = a;
        @(posedge clk); #1;
        dl_valid = 1'b0;
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    localparam logic [31:0] BA = 32'h0000_1230; // set 0x23
    localparam logic [31:0] BX = 32'h0000_1A30; // set 0x23, other tag
    localparam logic [31:0] BB = 32'h0000_5670; // set 0x67

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL R8 watchdog: actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        checks++;
        if (resp_valid !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset state: actual resp_valid=%0b expected 0", resp_valid);
        end
        miss(BA, "R1 empty table");

        // R3: decode-allocated conditional starts weakly not-taken
        update(1'b0, BA + 4, 32'h8000, 1'b0, 1'b0);
        miss(BA, "R3 fresh conditional not taken");
        // R4: retire trains counter and clears speculative flag
        update(1'b1, BA + 4, 32'h8000, 1'b0, 1'b1);
        lookup(BA, 1'b1, 4'h4, 32'h8000, 1'b0, 1'b0, "R4 trained taken");

        // R5/R6: unconditional at offset A, earliest taken wins
        update(1'b0, BA + 32'hA, 32'h9000, 1'b1, 1'b0);
        lookup(BA, 1'b1, 4'h4, 32'h8000, 1'b0, 1'b0, "R6 earliest taken");
        lookup(BA + 5, 1'b1, 4'hA, 32'h9000, 1'b1, 1'b1, "R5 unconditional fresh taken");
        miss(BA + 32'hB, "R6 entry byte past all branches");
        miss(BX, "R2 tag mismatch");

        // R7: removal
        remove(BA + 32'hA);
        miss(BA + 5, "R7 removed entry");

        // R10: floor saturation (counter 10 -> 01 -> 00 -> 00 -> 01)
        update(1'b1, BA + 4, 32'h8000, 1'b0, 1'b0);
        update(1'b1, BA + 4, 32'h8000, 1'b0, 1'b0);
        update(1'b1, BA + 4, 32'h8000, 1'b0, 1'b0);
        update(1'b1, BA + 4, 32'h8000, 1'b0, 1'b1);
        miss(BA, "R10 floor saturation");
        update(1'b1, BA + 4, 32'h8000, 1'b0, 1'b1);
        lookup(BA, 1'b1, 4'h4, 32'h8000, 1'b0, 1'b0, "R10 counter 10 taken");
        // R10: ceiling saturation (10 -> 11 -> 11 -> 11 -> 10)
        update(1'b1, BA + 4, 32'h8000, 1'b0, 1'b1);
        update(1'b1, BA + 4, 32'h8000, 1'b0, 1'b1);
        update(1'b1, BA + 4, 32'h8000, 1'b0, 1'b1);
        update(1'b1, BA + 4, 32'h8000, 1'b0, 1'b0);
        lookup(BA, 1'b1, 4'h4, 32'h8000, 1'b0, 1'b0, "R10 ceiling saturation");

        // R4: retire of an absent branch allocates it non-speculative
        update(1'b1, BA + 8, 32'h7000, 1'b0, 1'b1);
        lookup(BA + 5, 1'b1, 4'h8, 32'h7000, 1'b0, 1'b0, "R4 retire allocate");

        // R2: new tag in same set discards the old block
        update(1'b0, BX + 2, 32'h6000, 1'b1, 1'b0);
        miss(BA, "R2 old block discarded");
        lookup(BX, 1'b1, 4'h2, 32'h6000, 1'b1, 1'b1, "R2 new block installed");

        // R9: fill a set, then replacement by pseudo-LRU
        update(1'b0, BB + 0,      32'h100, 1'b1, 1'b0);
        update(1'b0, BB + 4,      32'h104, 1'b1, 1'b0);
        update(1'b0, BB + 8,      32'h108, 1'b1, 1'b0);
        update(1'b0, BB + 32'hC,  32'h10C, 1'b1, 1'b0);
        update(1'b0, BB + 2,      32'h102, 1'b1, 1'b0);  // evicts way0 (offset 0)
        lookup(BB, 1'b1, 4'h2, 32'h102, 1'b1, 1'b1, "R9 way0 replaced");
        lookup(BB + 3, 1'b1, 4'h4, 32'h104, 1'b1, 1'b1, "R9 way1 kept");
        update(1'b0, BB + 6,      32'h106, 1'b1, 1'b0);  // evicts way2 (offset 8)
        lookup(BB + 5, 1'b1, 4'h6, 32'h106, 1'b1, 1'b1, "R9 new entry offset 6");
        lookup(BB + 7, 1'b1, 4'hC, 32'h10C, 1'b1, 1'b1, "R9 way2 evicted");

        repeat (3) @(posedge clk);
        #1;
        checks++;
        if (sb_q.size() != 0) begin
            errors++;
            $display("FAIL R8 missing responses: actual=%0d pending expected=0", sb_q.size());
        end
        summary();
        $finish;
    end
endmodule